// File: doc/BRIEF.md
# JTAG Mailbox Bridge

This block sits behind a boundary-scan test access port and gives an external debugger a word-wide mailbox into the processor. One scan data register carries a complete access: a direction flag, a register address and a data word. The TAP controller is outside the block and supplies three strobes: capture, shift and update. The access is decoded on the update strobe. A write moves the scanned word into an inbound mailbox slot. A read latches a result, and the next scan returns it.

The debugger sees two registers. The status register is read-only and holds two handshake flags. The data register takes writes into the inbound slot and returns reads from the outbound slot. The processor side uses single-cycle strobes. `cpu_rd` consumes the inbound word and `cpu_wr` posts an outbound word. The two flags are visible to the processor as well, so each side knows when the other has taken its word.

All strobes are sampled on the single block clock. It is assumed that the JTAG strobes have already been brought into that clock domain, one cycle per TAP action.

Top module: `jtag_mbox_bridge`

## Requirements
- R1: The scan register is 38 bits and shifts LSB first. While `shift_dr` is high, each clock moves `tdi` into bit 37 and every bit one place toward bit 0. `tdo` always shows bit 0. The data word is bits 31:0, the address is bits 36:32 and the direction flag is bit 37 (1 = write, 0 = read).
- R2: A `capture_dr` cycle loads bits 31:0 with the latched read result and clears bits 37:32. The latched result is zero after reset.
- R3: An update with the flag at 1, address 0x05 and the inbound-full flag at 0 stores bits 31:0 as the inbound word and sets inbound-full. The inbound word is visible on `cpu_rdata`.
- R4: An update with the flag at 0 and address 0x04 latches the status word. Bit 0 is inbound-full and bit 1 is outbound-full, both as they stood before that update, and all other bits are 0. The following scan shifts this word out.
- R5: A write to address 0x05 while inbound-full is 1 is dropped. The stored inbound word is unchanged.
- R6: A write to address 0x04 has no effect on either flag or on either stored word.
- R7: A `cpu_wr` cycle stores `cpu_wdata` as the outbound word and sets outbound-full, shown on `cpu_tx_full`.
- R8: An update with the flag at 0 and address 0x05 latches the outbound word for the next scan and clears outbound-full.
- R9: A `cpu_rd` cycle clears inbound-full, shown on `cpu_rx_full`.
- R10: A read of any address other than 0x04 and 0x05 latches a result of zero and changes neither flag.
- R11: After reset both flags are 0 and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tdi | input | 1 | Serial data into the scan register |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| tdo | output | 1 | Serial data out of the scan register |
| cpu_wr | input | 1 | Processor posts an outbound word |
| cpu_wdata | input | 32 | Outbound word from the processor |
| cpu_rd | input | 1 | Processor consumes the inbound word |
| cpu_rdata | output | 32 | Inbound word to the processor |
| cpu_rx_full | output | 1 | Inbound word waiting (R flag) |
| cpu_tx_full | output | 1 | Outbound word waiting (W flag) |

## Verification
The hardest case to reach is a write to the data address that must be dropped. It needs the inbound flag already set, and then a second full 38-bit scan carrying a different word, with no processor read in between. A read result is only observable one scan later, so the scan that checks one access also carries the next.

The directed opening works through both of those cases. It also covers a write to the status address, a status read taken while a word is waiting, and a read of an unmapped address. A seeded random phase then mixes scans with random direction, address and data with processor reads and writes. A bench model predicts every shifted-out word and both flags.

// File: rtl/jmb_pkg.sv
package jmb_pkg;

   // Decoded debugger access, valid for the single update cycle
   typedef enum logic [2:0] {
      JMB_OP_IDLE    = 3'd0,
      JMB_OP_WR_DATA = 3'd1,
      JMB_OP_WR_DROP = 3'd2,
      JMB_OP_WR_IGN  = 3'd3,
      JMB_OP_RD_STAT = 3'd4,
      JMB_OP_RD_DATA = 3'd5,
      JMB_OP_RD_NONE = 3'd6
   } jmb_op_e;

   localparam int unsigned JMB_STAT_BITS = 2;

endpackage

// File: rtl/jmb_scan_chain.sv
module jmb_scan_chain #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tdi,
   input  logic              capture,
   input  logic              shift,
   input  logic [DATA_W-1:0] cap_word,
   output logic              tdo,
   output logic [DATA_W-1:0] sc_data,
   output logic [ADDR_W-1:0] sc_addr,
   output logic              sc_write
);

   localparam int unsigned CHAIN_W = DATA_W + ADDR_W + 1;
   localparam int unsigned HDR_W   = ADDR_W + 1;

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (capture) begin
         chain_q <= {{HDR_W{1'b0}}, cap_word};
      end else if (shift) begin
         chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
      end
   end

   assign tdo      = chain_q[0];
   assign sc_data  = chain_q[DATA_W-1:0];
   assign sc_addr  = chain_q[DATA_W +: ADDR_W];
   assign sc_write = chain_q[CHAIN_W-1];

   AST_SHIFT_LSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !capture) |=> (chain_q == {$past(tdi), $past(chain_q[CHAIN_W-1:1])})) // R1
      else $error("scan shift order broken");

   AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (sc_data == $past(cap_word) && sc_addr == '0 && !sc_write)) // R2
      else $error("capture load wrong");

endmodule

// File: rtl/jmb_access_decode.sv
module jmb_access_decode
   import jmb_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned STAT_ADDR = 4,
   parameter int unsigned DATA_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              update,
   input  logic              sc_write,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic              rx_full,
   input  logic              tx_full,
   input  logic [DATA_W-1:0] tx_word,
   output jmb_op_e           op,
   output logic [DATA_W-1:0] rd_result
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
   localparam int unsigned       PAD_W  = DATA_W - JMB_STAT_BITS;

   logic [DATA_W-1:0] stat_word;
   assign stat_word = {{PAD_W{1'b0}}, tx_full, rx_full};

   always_comb begin
      op = JMB_OP_IDLE;
      if (update) begin
         if (sc_write) begin
            if (sc_addr == DATA_A)      op = rx_full ? JMB_OP_WR_DROP : JMB_OP_WR_DATA;
            else                        op = JMB_OP_WR_IGN;
         end else begin
            if (sc_addr == STAT_A)      op = JMB_OP_RD_STAT;
            else if (sc_addr == DATA_A) op = JMB_OP_RD_DATA;
            else                        op = JMB_OP_RD_NONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_result <= '0;
      end else begin
         unique case (op)
            JMB_OP_RD_STAT: rd_result <= stat_word;
            JMB_OP_RD_DATA: rd_result <= tx_word;
            JMB_OP_RD_NONE: rd_result <= '0;
            default:        rd_result <= rd_result;
         endcase
      end
   end

   AST_STATUS_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == JMB_OP_RD_STAT) |=> (rd_result[1] == $past(tx_full) && rd_result[0] == $past(rx_full)
                                  && rd_result[DATA_W-1:2] == '0)) // R4
      else $error("status snapshot wrong");

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op == JMB_OP_RD_NONE) |=> (rd_result == '0)) // R10
      else $error("unmapped read not zero");

   AST_WRITE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == JMB_OP_WR_IGN || op == JMB_OP_WR_DROP) |=> $stable(rd_result)) // R6
      else $error("write disturbed read result");

endmodule

// File: rtl/jmb_mailbox.sv
module jmb_mailbox
   import jmb_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  jmb_op_e           op,
   input  logic [DATA_W-1:0] dbg_word,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_full,
   output logic [DATA_W-1:0] tx_word,
   output logic              tx_full
);

   // Inbound slot: debugger to processor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word <= '0;
         rx_full <= 1'b0;
      end else if (op == JMB_OP_WR_DATA) begin
         rx_word <= dbg_word;
         rx_full <= 1'b1;
      end else if (cpu_rd) begin
         rx_full <= 1'b0;
      end
   end

   // Outbound slot: processor to debugger; a new post wins over a same-cycle read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_word <= '0;
         tx_full <= 1'b0;
      end else if (cpu_wr) begin
         tx_word <= cpu_wdata;
         tx_full <= 1'b1;
      end else if (op == JMB_OP_RD_DATA) begin
         tx_full <= 1'b0;
      end
   end

   AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == JMB_OP_WR_DATA) |=> (rx_full && rx_word == $past(dbg_word))) // R3
      else $error("inbound write not stored");

   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op != JMB_OP_WR_DATA) |=> $stable(rx_word)) // R5
      else $error("inbound word changed without accepted write");

   AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && op != JMB_OP_WR_DATA) |=> !rx_full) // R9
      else $error("inbound flag not cleared");

   AST_TX_POST: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |=> (tx_full && tx_word == $past(cpu_wdata))) // R7
      else $error("outbound post lost");

   AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op == JMB_OP_RD_DATA && !cpu_wr) |=> !tx_full) // R8
      else $error("outbound flag not cleared");

endmodule

// File: rtl/jtag_mbox_bridge.sv
module jtag_mbox_bridge
   import jmb_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned STAT_ADDR = 4,
   parameter int unsigned DATA_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tdi,
   input  logic              capture_dr,
   input  logic              shift_dr,
   input  logic              update_dr,
   output logic              tdo,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_rx_full,
   output logic              cpu_tx_full
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < JMB_STAT_BITS) begin : g_bad_data_w
      $error("DATA_W must hold the status bits");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W out of range");
   end
   if (STAT_ADDR >= ADDR_SPAN || DATA_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("register address does not fit ADDR_W");
   end
   if (STAT_ADDR == DATA_ADDR) begin : g_addr_clash
      $error("status and data addresses must differ");
   end

   logic [DATA_W-1:0] sc_data;
   logic [ADDR_W-1:0] sc_addr;
   logic              sc_write;
   logic [DATA_W-1:0] rd_result;
   logic [DATA_W-1:0] tx_word;
   logic              rx_full;
   logic              tx_full;
   jmb_op_e           op;

   jmb_scan_chain #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .tdi      (tdi),
      .capture  (capture_dr),
      .shift    (shift_dr),
      .cap_word (rd_result),
      .tdo      (tdo),
      .sc_data  (sc_data),
      .sc_addr  (sc_addr),
      .sc_write (sc_write)
   );

   jmb_access_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .update    (update_dr),
      .sc_write  (sc_write),
      .sc_addr   (sc_addr),
      .rx_full   (rx_full),
      .tx_full   (tx_full),
      .tx_word   (tx_word),
      .op        (op),
      .rd_result (rd_result)
   );

   jmb_mailbox #(.DATA_W(DATA_W)) u_mbox (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .dbg_word  (sc_data),
      .cpu_wr    (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .cpu_rd    (cpu_rd),
      .rx_word   (cpu_rdata),
      .rx_full   (rx_full),
      .tx_word   (tx_word),
      .tx_full   (tx_full)
   );

   assign cpu_rx_full = rx_full;
   assign cpu_tx_full = tx_full;

   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (update_dr && sc_write && sc_addr == ADDR_W'(STAT_ADDR) && !cpu_rd && !cpu_wr)
      |=> ($stable(rx_full) && $stable(tx_full) && $stable(cpu_rdata))) // R6
      else $error("status write had an effect");

endmodule

// File: tb/jtag_mbox_bridge_tb.sv
`timescale 1ns/1ps
module jtag_mbox_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic        tdo;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_rx_full, cpu_tx_full;

   always #4 clk = ~clk;   // 125 MHz

   jtag_mbox_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .tdo(tdo), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rx_full(cpu_rx_full),
      .cpu_tx_full(cpu_tx_full)
   );

   int unsigned n_chk = 0, n_fail = 0;
   logic        done = 1'b0;

   // bench model
   logic [31:0] m_rd = '0, m_in = '0, m_out = '0;
   logic        m_r = 1'b0, m_w = 1'b0;
   string       m_rd_tag = "R2";

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] status_word(input logic w, input logic r);
      return {30'd0, w, r};
   endfunction

   task automatic check_flags(input string tag);
      chk(cpu_rx_full == m_r, tag, 64'(cpu_rx_full), 64'(m_r));
      chk(cpu_tx_full == m_w, tag, 64'(cpu_tx_full), 64'(m_w));
      chk(cpu_rdata == m_in, tag, 64'(cpu_rdata), 64'(m_in));
   endtask

   // One full capture / shift / update sequence; inputs change on falling edges
   task automatic dbg_scan(input logic wr, input logic [4:0] addr, input logic [31:0] data,
                           input string tag);
      logic [37:0] din, dout;
      din = {wr, addr, data};
      @(negedge clk); capture_dr = 1'b1;
      @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1;
      for (int i = 0; i < 38; i++) begin
         tdi = din[i];
         dout[i] = tdo;
         @(negedge clk);
      end
      shift_dr = 1'b0; update_dr = 1'b1;
      @(negedge clk); update_dr = 1'b0;
      // returned word is the previous read result (R1 order, R2 upper bits zero)
      chk(dout[31:0] == m_rd, m_rd_tag, 64'(dout[31:0]), 64'(m_rd));
      chk(dout[37:32] == 6'd0, "R2", 64'(dout[37:32]), 64'd0);
      if (wr) begin
         if (addr == 5'h05 && !m_r) begin m_in = data; m_r = 1'b1; end
      end else begin
         if (addr == 5'h04)      begin m_rd = status_word(m_w, m_r); m_rd_tag = "R4"; end
         else if (addr == 5'h05) begin m_rd = m_out; m_w = 1'b0; m_rd_tag = "R8"; end
         else                    begin m_rd = '0; m_rd_tag = "R10"; end
      end
      check_flags(tag);
   endtask

   task automatic proc_write(input logic [31:0] w);
      @(negedge clk); cpu_wr = 1'b1; cpu_wdata = w;
      @(negedge clk); cpu_wr = 1'b0;
      m_out = w; m_w = 1'b1;
      check_flags("R7");
   endtask

   task automatic proc_read();
      chk(cpu_rdata == m_in, "R3", 64'(cpu_rdata), 64'(m_in));
      @(negedge clk); cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0;
      m_r = 1'b0;
      check_flags("R9");
   endtask

   initial begin
      int unsigned seed_tap;
      seed_tap = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(cpu_rx_full == 1'b0, "R11", 64'(cpu_rx_full), 64'd0);
      chk(cpu_tx_full == 1'b0, "R11", 64'(cpu_tx_full), 64'd0);
      chk(tdo == 1'b0, "R11", 64'(tdo), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      dbg_scan(1'b0, 5'h04, 32'h0, "R4");            // returns reset result (R2)
      dbg_scan(1'b1, 5'h05, 32'hA5A5_1234, "R3");    // accepted
      dbg_scan(1'b1, 5'h05, 32'hDEAD_BEEF, "R5");    // dropped, R still set
      dbg_scan(1'b0, 5'h04, 32'h0, "R4");            // status while word waits
      dbg_scan(1'b1, 5'h04, 32'hFFFF_FFFF, "R6");    // ignored; returns status 1
      proc_read();
      proc_write(32'h0BAD_F00D);
      dbg_scan(1'b0, 5'h05, 32'h0, "R8");            // clears W
      dbg_scan(1'b0, 5'h1F, 32'h0, "R10");           // returns outbound word
      dbg_scan(1'b0, 5'h04, 32'h0, "R4");            // returns zero of unmapped read

      for (int n = 0; n < 400; n++) begin
         int unsigned pick;
         logic [4:0]  a;
         pick = $urandom_range(0, 9);
         case ($urandom_range(0, 3))
            0: a = 5'h04;
            1, 2: a = 5'h05;
            default: a = 5'($urandom);
         endcase
         if (pick < 6)      dbg_scan(pick[0], a, $urandom, "R1");
         else if (pick < 8) proc_write($urandom);
         else               proc_read();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule